// File: doc/BRIEF.md
# Phase-Sequenced Fetch/Execute Controller

This block sets the pace of a small processor core. Every instruction cycle is split into four clock-wide phases. While the core decodes and executes one instruction word, the block fetches the word that follows it. It keeps a byte-addressed program counter, captures each fetched word into an instruction register, and raises phase strobes so that the datapath knows when to read its operand and when to write its result.

Decode reports a taken branch in the last phase of a cycle. The branch either names an absolute word target or gives a signed offset counted in instruction words. The word that was fetched behind the branch is thrown away and a NOP runs in its place while the target is fetched. Program memory is modelled outside the block as a byte array: a 16-bit word is returned from a byte address whose bit 0 is zero.

Top module: `iseq_core`

## Requirements
- R1: `phase_o` steps 0,1,2,3 (Q1..Q4) on successive clocks and goes from 3 back to 0; one instruction cycle is four clocks.
- R2: `q_rd_o` is high exactly while `phase_o` is 1 (Q2), and `q_wr_o` is high exactly while `phase_o` is 3 (Q4).
- R3: With no branch taken, `pmem_addr_o` rises by 2 (modulo 2^21) on the clock that enters Q1 and holds its value through Q2, Q3 and Q4.
- R4: On entry to Q1, `ir_o` loads the word that `imem_data_i` presented in the preceding Q4, which is the word at `pmem_addr_o` with its low byte at the even address and its high byte at the odd address. `ir_o` then holds for the whole cycle.
- R5: Bit 0 of `pmem_addr_o` is always 0.
- R6: When `br_abs_i` is high in Q4, `pmem_addr_o` becomes `{br_word_i, 1'b0}` at the next Q1.
- R7: When `br_rel_i` is high in Q4 (and `br_abs_i` is low), `pmem_addr_o` becomes its current value plus two times the sign-extended `br_off_i`, modulo 2^21. The current value is the address of the word that follows the branch.
- R8: After a taken branch, `ir_o` is 16'h0000 and `fetch_nop_o` is 1 for one instruction cycle. The branch target executes in the cycle after that. `fetch_nop_o` is 0 in every cycle that executes a fetched word.
- R9: Branch requests held in Q1, Q2 or Q3 have no effect on the address or on the instruction register.
- R10: When `br_abs_i` and `br_rel_i` are both high in Q4, the absolute target wins.
- R11: While `rst_ni` is low, `pmem_addr_o` is 0, `phase_o` is 0, `ir_o` is 16'h0000 and `fetch_nop_o` is 1. The first cycle after reset therefore executes a NOP while it fetches address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one period per phase |
| rst_ni | input | 1 | Asynchronous active-low reset |
| imem_data_i | input | 16 | Word read from program memory at `pmem_addr_o` |
| br_abs_i | input | 1 | Absolute branch request, sampled in Q4 |
| br_word_i | input | 20 | Absolute target as a word address |
| br_rel_i | input | 1 | Relative branch request, sampled in Q4 |
| br_off_i | input | 11 | Signed relative offset in instruction words |
| pmem_addr_o | output | 21 | Program memory byte address (program counter) |
| ir_o | output | 16 | Instruction register |
| phase_o | output | 2 | Current phase, 0..3 for Q1..Q4 |
| q_rd_o | output | 1 | Operand read strobe (Q2) |
| q_wr_o | output | 1 | Destination write strobe (Q4) |
| fetch_nop_o | output | 1 | The word in `ir_o` is a forced NOP |

## Verification
The bench first runs a stretch of straight-line cycles. These show that the address steps by two and that each fetched word, built from two bytes, lands in the register one cycle later. It then sweeps relative offsets from -8 to +8 and adds the two extreme offsets. This exposes sign-extension and shift faults that a single offset would hide. Absolute jumps include the top word address, so the following increment shows the address wrapping to zero. Requests made together check the priority order. Requests raised only in Q1..Q3 must change nothing, which separates a design that samples in Q4 from one that samples in every phase.

// File: rtl/iseq_pkg.sv
package iseq_pkg;

   typedef enum logic [1:0] {
      PH_Q1 = 2'd0,
      PH_Q2 = 2'd1,
      PH_Q3 = 2'd2,
      PH_Q4 = 2'd3
   } phase_e;

   localparam int unsigned PHASES_PER_CYCLE = 4;

endpackage

// File: rtl/iseq_phase_gen.sv
module iseq_phase_gen
   import iseq_pkg::*;
(
   input  logic   clk_i,
   input  logic   rst_ni,
   output phase_e phase_o,
   output logic   rd_stb_o,
   output logic   wr_stb_o,
   output logic   cyc_end_o
);

   phase_e ph_q;
   phase_e ph_d;

   always_comb begin
      unique case (ph_q)
         PH_Q1:   ph_d = PH_Q2;
         PH_Q2:   ph_d = PH_Q3;
         PH_Q3:   ph_d = PH_Q4;
         default: ph_d = PH_Q1;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ph_q <= PH_Q1;
      else         ph_q <= ph_d;
   end

   assign phase_o   = ph_q;
   assign rd_stb_o  = (ph_q == PH_Q2);
   assign wr_stb_o  = (ph_q == PH_Q4);
   assign cyc_end_o = (ph_q == PH_Q4);

   assert_phase_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_Q4) |=> (ph_q == PH_Q1));

   assert_phase_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q != PH_Q4) |=> (2'(ph_q) == 2'(2'($past(ph_q)) + 2'd1)));

   assert_strobe_excl_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rd_stb_o && wr_stb_o));

   assert_rd_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rd_stb_o |=> !rd_stb_o);

endmodule

// File: rtl/iseq_pc_unit.sv
module iseq_pc_unit #(
   parameter int unsigned PC_W   = 21,
   parameter int unsigned OFF_W  = 11,
   parameter bit          REL_EN = 1'b1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              cyc_end_i,
   input  logic              br_abs_i,
   input  logic [PC_W-2:0]   br_word_i,
   input  logic              br_rel_i,
   input  logic [OFF_W-1:0]  br_off_i,
   output logic [PC_W-1:0]   pc_o,
   output logic              take_o
);

   localparam int unsigned EXT_W = PC_W - OFF_W;

   logic [PC_W-1:0] pc_q;
   logic [PC_W-1:0] pc_d;
   logic [PC_W-1:0] pc_seq;
   logic [PC_W-1:0] pc_abs;
   logic [PC_W-1:0] pc_rel;
   logic            rel_req;

   assign pc_seq = pc_q + PC_W'(2);
   assign pc_abs = {br_word_i, 1'b0};

   generate
      if (REL_EN) begin : g_rel
         logic [PC_W-1:0] off_ext;
         assign off_ext = {{EXT_W{br_off_i[OFF_W-1]}}, br_off_i};
         assign pc_rel  = pc_q + {off_ext[PC_W-2:0], 1'b0};
         assign rel_req = br_rel_i;
      end else begin : g_norel
         logic unused_rel;
         assign unused_rel = br_rel_i ^ (^br_off_i);
         assign pc_rel     = pc_seq;
         assign rel_req    = 1'b0;
      end
   endgenerate

   assign take_o = cyc_end_i && (br_abs_i || rel_req);

   always_comb begin
      if (!cyc_end_i)    pc_d = pc_q;
      else if (br_abs_i) pc_d = pc_abs;
      else if (rel_req)  pc_d = pc_rel;
      else               pc_d = pc_seq;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pc_q <= '0;
      else         pc_q <= pc_d;
   end

   assign pc_o = pc_q;

   assert_pc_even_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      pc_q[0] == 1'b0);

   assert_pc_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cyc_end_i |=> $stable(pc_q));

   assert_pc_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_end_i && !br_abs_i && !br_rel_i) |=> (pc_q == PC_W'($past(pc_q) + PC_W'(2))));

   assert_pc_abs_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_end_i && br_abs_i) |=> (pc_q[PC_W-1:1] == $past(br_word_i)));

   assert_abs_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_end_i && br_abs_i && br_rel_i) |=> (pc_q == {$past(br_word_i), 1'b0}));

endmodule

// File: rtl/iseq_ir_stage.sv
module iseq_ir_stage #(
   parameter int unsigned     INSTR_W  = 16,
   parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               cyc_end_i,
   input  logic               flush_i,
   input  logic [INSTR_W-1:0] fetch_i,
   output logic [INSTR_W-1:0] ir_o,
   output logic               nop_o
);

   logic [INSTR_W-1:0] ir_q;
   logic               nop_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ir_q  <= NOP_WORD;
         nop_q <= 1'b1;
      end else if (cyc_end_i) begin
         ir_q  <= flush_i ? NOP_WORD : fetch_i;
         nop_q <= flush_i;
      end
   end

   assign ir_o  = ir_q;
   assign nop_o = nop_q;

   assert_ir_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !cyc_end_i |=> ($stable(ir_q) && $stable(nop_q)));

   assert_ir_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_end_i && !flush_i) |=> ((ir_q == $past(fetch_i)) && !nop_q));

   assert_flush_nop_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cyc_end_i && flush_i) |=> ((ir_q == NOP_WORD) && nop_q));

endmodule

// File: rtl/iseq_core.sv
module iseq_core #(
   parameter int unsigned PC_W     = 21,
   parameter int unsigned INSTR_W  = 16,
   parameter int unsigned OFF_W    = 11,
   parameter bit          REL_EN   = 1'b1,
   parameter logic [INSTR_W-1:0] NOP_WORD = '0
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic [INSTR_W-1:0] imem_data_i,
   input  logic               br_abs_i,
   input  logic [PC_W-2:0]    br_word_i,
   input  logic               br_rel_i,
   input  logic [OFF_W-1:0]   br_off_i,
   output logic [PC_W-1:0]    pmem_addr_o,
   output logic [INSTR_W-1:0] ir_o,
   output logic [1:0]         phase_o,
   output logic               q_rd_o,
   output logic               q_wr_o,
   output logic               fetch_nop_o
);
   import iseq_pkg::*;

   generate
      if (PC_W < 4)
         $error("iseq_core: PC_W must be at least 4");
      if ((OFF_W < 2) || (OFF_W >= PC_W))
         $error("iseq_core: OFF_W must lie in 2..PC_W-1");
      if ((INSTR_W < 8) || ((INSTR_W % 8) != 0))
         $error("iseq_core: INSTR_W must be a whole number of bytes");
   endgenerate

   phase_e ph;
   logic   cyc_end;
   logic   take;

   iseq_phase_gen u_phase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .phase_o   (ph),
      .rd_stb_o  (q_rd_o),
      .wr_stb_o  (q_wr_o),
      .cyc_end_o (cyc_end)
   );

   iseq_pc_unit #(
      .PC_W   (PC_W),
      .OFF_W  (OFF_W),
      .REL_EN (REL_EN)
   ) u_pc (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cyc_end_i (cyc_end),
      .br_abs_i  (br_abs_i),
      .br_word_i (br_word_i),
      .br_rel_i  (br_rel_i),
      .br_off_i  (br_off_i),
      .pc_o      (pmem_addr_o),
      .take_o    (take)
   );

   iseq_ir_stage #(
      .INSTR_W  (INSTR_W),
      .NOP_WORD (NOP_WORD)
   ) u_ir (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .cyc_end_i (cyc_end),
      .flush_i   (take),
      .fetch_i   (imem_data_i),
      .ir_o      (ir_o),
      .nop_o     (fetch_nop_o)
   );

   assign phase_o = 2'(ph);

   assert_addr_moves_at_q1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pmem_addr_o != $past(pmem_addr_o)) |-> (phase_o == 2'd0));

endmodule

// File: tb/iseq_core_tb.sv
module iseq_core_tb;

   localparam int CLK_PERIOD = 10;

   logic        clk_i = 1'b0;
   logic        rst_ni = 1'b0;
   logic [15:0] imem_data_i;
   logic        br_abs_i = 1'b0;
   logic [19:0] br_word_i = '0;
   logic        br_rel_i = 1'b0;
   logic [10:0] br_off_i = '0;
   logic [20:0] pmem_addr_o;
   logic [15:0] ir_o;
   logic [1:0]  phase_o;
   logic        q_rd_o;
   logic        q_wr_o;
   logic        fetch_nop_o;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   logic [20:0] m_pc;
   logic [15:0] m_ir;
   logic        m_nop;
   int          m_ph;
   string       addr_tag;

   always #(CLK_PERIOD/2) clk_i = ~clk_i;

   function automatic logic [7:0] mem_byte(input logic [7:0] a);
      return 8'(a * 8'd29 + 8'd101);
   endfunction

   function automatic logic [15:0] word_at(input logic [20:0] a);
      logic [7:0] lo_a;
      lo_a = {a[7:1], 1'b0};
      return {mem_byte(lo_a | 8'd1), mem_byte(lo_a)};
   endfunction

   assign imem_data_i = word_at(pmem_addr_o);

   iseq_core u_dut (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .imem_data_i (imem_data_i),
      .br_abs_i    (br_abs_i),
      .br_word_i   (br_word_i),
      .br_rel_i    (br_rel_i),
      .br_off_i    (br_off_i),
      .pmem_addr_o (pmem_addr_o),
      .ir_o        (ir_o),
      .phase_o     (phase_o),
      .q_rd_o      (q_rd_o),
      .q_wr_o      (q_wr_o),
      .fetch_nop_o (fetch_nop_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic check_outputs();
      chk("R1 phase", 32'(phase_o), 32'(m_ph));
      chk("R2 rd strobe", 32'(q_rd_o), 32'(m_ph == 1));
      chk("R2 wr strobe", 32'(q_wr_o), 32'(m_ph == 3));
      chk({addr_tag, " address"}, 32'(pmem_addr_o), 32'(m_pc));
      chk("R5 address bit0", 32'(pmem_addr_o[0]), 32'd0);
      chk(m_nop ? "R8 ir" : "R4 ir", 32'(ir_o), 32'(m_ir));
      chk("R8 nop flag", 32'(fetch_nop_o), 32'(m_nop));
   endtask

   // mode 0: requests only in Q4; mode 1: requests only in Q1..Q3 (must be ignored)
   task automatic run_cycle(input logic abs, input logic [19:0] w, input logic rel,
                            input logic [10:0] off, input int mode);
      for (int ph = 0; ph < 4; ph++) begin
         logic drive;
         check_outputs();
         drive     = (mode == 0) ? (ph == 3) : (ph != 3);
         br_abs_i  = drive ? abs : 1'b0;
         br_rel_i  = drive ? rel : 1'b0;
         br_word_i = w;
         br_off_i  = off;
         @(posedge clk_i);
         if (m_ph == 3) begin
            logic        t_abs;
            logic        t_rel;
            logic [20:0] se;
            t_abs = br_abs_i;
            t_rel = br_rel_i;
            se    = {{10{off[10]}}, off};
            m_ir  = (t_abs || t_rel) ? 16'h0000 : word_at(m_pc);
            m_nop = t_abs || t_rel;
            if (t_abs) m_pc = {w, 1'b0};
            else if (t_rel) m_pc = 21'(m_pc + (se << 1));
            else m_pc = 21'(m_pc + 21'd2);
            if (t_abs && t_rel) addr_tag = "R10";
            else if (t_abs) addr_tag = "R6";
            else if (t_rel) addr_tag = "R7";
            else if (mode == 1) addr_tag = "R9";
            else addr_tag = "R3";
         end
         m_ph = (m_ph + 1) % 4;
         @(negedge clk_i);
      end
   endtask

   task automatic plain(input int n);
      for (int i = 0; i < n; i++) run_cycle(1'b0, '0, 1'b0, '0, 0);
   endtask

   initial begin
      m_pc = '0; m_ir = 16'h0000; m_nop = 1'b1; m_ph = 0; addr_tag = "R11";
      repeat (3) @(negedge clk_i);
      chk("R11 reset address", 32'(pmem_addr_o), 32'd0);
      chk("R11 reset phase", 32'(phase_o), 32'd0);
      chk("R11 reset ir", 32'(ir_o), 32'h0000);
      chk("R11 reset nop flag", 32'(fetch_nop_o), 32'd1);
      rst_ni = 1'b1;
      addr_tag = "R3";
      plain(6);
      run_cycle(1'b1, 20'h00010, 1'b0, '0, 0);
      plain(3);
      for (int o = -8; o <= 8; o++) begin
         run_cycle(1'b0, '0, 1'b1, 11'(o), 0);
         plain(2);
      end
      run_cycle(1'b0, '0, 1'b1, 11'h400, 0);
      plain(2);
      run_cycle(1'b0, '0, 1'b1, 11'h3FF, 0);
      plain(2);
      run_cycle(1'b1, 20'hFFFFF, 1'b0, '0, 0);
      plain(3);
      run_cycle(1'b1, 20'h00040, 1'b1, 11'h005, 0);
      plain(2);
      run_cycle(1'b1, 20'h00123, 1'b1, 11'h7F0, 1);
      run_cycle(1'b0, '0, 1'b1, 11'h010, 1);
      plain(2);
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk_i);
      if (!done) begin
         n_chk++;
         n_err++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
         $finish;
      end
   end

endmodule